// File: doc/BRIEF.md
# Configurable registered address buffer

This block registers a memory command and address bus on the rising clock edge and drives registered copies toward the memory devices. Two static straps set its layout. With the pairing strap low the block works as a 25-bit one-to-one register. With the pairing strap high it works as a 14-bit register whose every captured bit drives two output positions. In that case a second strap picks which slice of the input bus the device serves, so that two devices can split one bus between them.

Two active-low chip-select inputs give a standby gate. When both are high at a clock edge, the registered outputs keep their values. When either one is low, the outputs load the new inputs. The chip-select input `dcs_n` is also carried through as a registered copy on `q_cs`. An active-low reset, asynchronous to the clock, clears every register at once and takes priority over the gating.

Top module: `addrbuf_top`

## Requirements
- R1: With `cfg_pair`=0, at each rising clock edge where the gate is open, `q_out[i]` takes `d_in[i]` for every i from 0 to 24.
- R2: With `cfg_pair`=1, output positions k and k+14 carry the same captured bit, for every k from 0 to 13.
- R3: With `cfg_pair`=1 and `cfg_upper`=0, `q_out[k]` takes `d_in[k]`. With `cfg_upper`=1, `q_out[k]` takes `d_in[k+11]`. With `cfg_pair`=0, `cfg_upper` has no effect.
- R4: When `dcs_n` and `csr_n` are both 1 at a rising edge, `q_out` and `q_cs` keep their previous values.
- R5: `rst_n`=0 drives `q_out` and `q_cs` to 0 at once, without waiting for a clock edge. This holds even while both chip selects are high.
- R6: With `cfg_pair`=0, `q_out[27:25]` is always 0.
- R7: With `csr_n`=0, `dcs_n` has no effect on the gate, and its value is registered on `q_cs` like any data bit.
- R8: After `rst_n` rises, the outputs stay 0 until the first rising clock edge.
- R9: The gate is decided by the `dcs_n` and `csr_n` values present at the same edge that would load the outputs. Earlier values play no part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pair | input | 1 | Static strap: 0 = 25-bit one-to-one, 1 = 14-bit one-to-two |
| cfg_upper | input | 1 | Static strap for the one-to-two mode: 0 = lower slice, 1 = upper slice |
| dcs_n | input | 1 | Chip select, active low; also registered onto q_cs |
| csr_n | input | 1 | Second chip select, active low |
| d_in | input | 25 | Command and address input bus |
| q_out | output | 28 | Registered output bus |
| q_cs | output | 1 | Registered copy of dcs_n |

## Verification
The stimulus mixes cycles with the gate closed and open. A design that samples the chip selects one cycle late would let data through on a closed cycle and freeze an open one. Each strap setting sees the same traffic, which exposes a wrong slice offset for the upper half, a mirror that is not duplicated correctly, or a wide mode that leaks data into the three unused outputs. Reset is pulled in the middle of a cycle while both chip selects are high, so a synchronous reset or one masked by the gate shows up as nonzero outputs. The outputs are also observed between reset release and the first edge, which catches a design that loads on the release.

// File: rtl/addrbuf_pkg.sv
package addrbuf_pkg;

    localparam int WIDE_W_DEF   = 25;
    localparam int NARROW_W_DEF = 14;

    // Output layout selected by the two static straps
    typedef enum logic [1:0] {
        MAP_WIDE    = 2'd0,
        MAP_PAIR_LO = 2'd1,
        MAP_PAIR_HI = 2'd2
    } map_mode_e;

    // Per-edge control handed to the capture stage
    typedef struct packed {
        logic hold;
        logic cs_bit;
    } cap_ctrl_t;

    function automatic map_mode_e decode_straps(input logic pair, input logic upper);
        if (!pair)
            return MAP_WIDE;
        else if (upper)
            return MAP_PAIR_HI;
        else
            return MAP_PAIR_LO;
    endfunction

    // Both selects deasserted means the bus is idle and the outputs freeze
    function automatic logic bus_idle(input logic sel_a_n, input logic sel_b_n);
        return sel_a_n & sel_b_n;
    endfunction

endpackage

// File: rtl/addrbuf_capture.sv
module addrbuf_capture
    import addrbuf_pkg::*;
#(
    parameter int WIDTH = WIDE_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cap_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] data_r,
    output logic             cs_r
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_r <= '0;
            cs_r   <= 1'b0;
        end else if (!ctrl.hold) begin
            data_r <= din;
            cs_r   <= ctrl.cs_bit;
        end
    end

endmodule

// File: rtl/addrbuf_fanout.sv
module addrbuf_fanout
    import addrbuf_pkg::*;
#(
    parameter int WIDE_W   = WIDE_W_DEF,
    parameter int NARROW_W = NARROW_W_DEF
) (
    input  map_mode_e            mode,
    input  logic [WIDE_W-1:0]    data_r,
    output logic [2*NARROW_W-1:0] q
);

    localparam int OUT_W   = 2 * NARROW_W;
    localparam int HI_BASE = WIDE_W - NARROW_W;

    for (genvar i = 0; i < OUT_W; i++) begin : g_pos
        localparam int K = i % NARROW_W;
        logic wide_bit;

        if (i < WIDE_W) begin : g_used
            assign wide_bit = data_r[i];
        end else begin : g_spare
            assign wide_bit = 1'b0;
        end

        always_comb begin
            unique case (mode)
                MAP_PAIR_LO: q[i] = data_r[K];
                MAP_PAIR_HI: q[i] = data_r[HI_BASE + K];
                default:     q[i] = wide_bit;
            endcase
        end
    end

endmodule

// File: rtl/addrbuf_top.sv
module addrbuf_top
    import addrbuf_pkg::*;
#(
    parameter int WIDE_W   = WIDE_W_DEF,
    parameter int NARROW_W = NARROW_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_pair,
    input  logic                  cfg_upper,
    input  logic                  dcs_n,
    input  logic                  csr_n,
    input  logic [WIDE_W-1:0]     d_in,
    output logic [2*NARROW_W-1:0] q_out,
    output logic                  q_cs
);

    map_mode_e         mode;
    cap_ctrl_t         ctrl;
    logic [WIDE_W-1:0] data_r;

    assign mode        = decode_straps(cfg_pair, cfg_upper);
    assign ctrl.hold   = bus_idle(dcs_n, csr_n);
    assign ctrl.cs_bit = dcs_n;

    addrbuf_capture #(.WIDTH(WIDE_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl),
        .din    (d_in),
        .data_r (data_r),
        .cs_r   (q_cs)
    );

    addrbuf_fanout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_map (
        .mode   (mode),
        .data_r (data_r),
        .q      (q_out)
    );

endmodule

// File: rtl/addrbuf_checker.sv
module addrbuf_checker #(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_pair,
    input logic                  dcs_n,
    input logic                  csr_n,
    input logic [WIDE_W-1:0]     d_in,
    input logic [2*NARROW_W-1:0] q_out,
    input logic                  q_cs
);

    localparam int OUT_W = 2 * NARROW_W;

    AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pair && !(dcs_n && csr_n)) |=> (q_out[WIDE_W-1:0] == $past(d_in))); // R1

    AST_PAIR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pair |-> (q_out[NARROW_W-1:0] == q_out[OUT_W-1:NARROW_W])); // R2

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (dcs_n && csr_n) |=> ($stable(q_out) && $stable(q_cs))); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (q_out == '0 && q_cs == 1'b0)); // R5

    AST_SPARE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pair |-> (q_out[OUT_W-1:WIDE_W] == '0)); // R6

    AST_CS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_n |=> (q_cs == $past(dcs_n))); // R7

endmodule

bind addrbuf_top addrbuf_checker #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_pair (cfg_pair),
    .dcs_n    (dcs_n),
    .csr_n    (csr_n),
    .d_in     (d_in),
    .q_out    (q_out),
    .q_cs     (q_cs)
);

// File: tb/addrbuf_tb.sv
module addrbuf_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [24:0] d;
        logic        dcs_n;
        logic        csr_n;
    } vec_t;

    // Stimulus; expected outputs follow from the running model below.
    // Hold rows placed between open rows exercise R9.
    localparam vec_t VECS [NVEC] = '{
        '{25'h0ABCDEF, 1'b0, 1'b0},
        '{25'h1FFFFFF, 1'b1, 1'b0},
        '{25'h0123456, 1'b1, 1'b1},
        '{25'h1555555, 1'b1, 1'b1},
        '{25'h0AAAAAA, 1'b0, 1'b1},
        '{25'h1000001, 1'b0, 1'b0},
        '{25'h0F0F0F0, 1'b1, 1'b1},
        '{25'h00FF00F, 1'b1, 1'b0},
        '{25'h1F00FF0, 1'b0, 1'b1},
        '{25'h0000000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pair = 1'b0;
    logic        cfg_upper = 1'b0;
    logic        dcs_n = 1'b1;
    logic        csr_n = 1'b1;
    logic [24:0] d_in = '0;
    logic [27:0] q_out;
    logic        q_cs;

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;

    logic [24:0] m_data = '0;
    logic        m_cs = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addrbuf_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_pair  (cfg_pair),
        .cfg_upper (cfg_upper),
        .dcs_n     (dcs_n),
        .csr_n     (csr_n),
        .d_in      (d_in),
        .q_out     (q_out),
        .q_cs      (q_cs)
    );

    function automatic logic [27:0] model_q(input logic [24:0] r, input logic pair, input logic upper);
        logic [13:0] s;
        if (!pair) return {3'b000, r};
        s = upper ? r[24:11] : r[13:0];
        return {s, s};
    endfunction

    task automatic check(input string tag, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, let one rising edge pass, then sample.
    task automatic step(input vec_t v, input string tag);
        d_in  = v.d;
        dcs_n = v.dcs_n;
        csr_n = v.csr_n;
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (!(v.dcs_n && v.csr_n)) begin
            m_data = v.d;
            m_cs   = v.dcs_n;
        end
        check(tag, q_out, model_q(m_data, cfg_pair, cfg_upper));
        check({tag, " cs"}, {27'd0, q_cs}, {27'd0, m_cs});
        @(negedge clk);
    endtask

    task automatic enter_mode(input logic pair, input logic upper);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        dcs_n = 1'b1;
        csr_n = 1'b1;
        #1;
        check("R5 async clear", {q_out, q_cs}, '0);
        cfg_pair  = pair;
        cfg_upper = upper;
        @(negedge clk);
        @(negedge clk);
        #(CLK_PERIOD/8);
        rst_n = 1'b1;
        m_data = '0;
        m_cs   = 1'b0;
        d_in   = 25'h1FFFFFF;
        dcs_n  = 1'b0;
        csr_n  = 1'b0;
        #1;
        check("R8 low after release", {q_out, q_cs}, '0);
        @(negedge clk);
        // the edge just passed had the gate open, so the model loads it
        m_data = 25'h1FFFFFF;
        m_cs   = 1'b0;
    endtask

    initial begin
        string tag;
        enter_mode(1'b0, 1'b0);
        check("R8 first edge loads", q_out, model_q(25'h1FFFFFF, 1'b0, 1'b0));

        for (int m = 0; m < 3; m++) begin
            if (m == 1) enter_mode(1'b1, 1'b0);
            if (m == 2) enter_mode(1'b1, 1'b1);
            for (int i = 0; i < NVEC; i++) begin
                if (VECS[i].dcs_n && VECS[i].csr_n) tag = "R4 hold";
                else if (VECS[i].dcs_n)             tag = "R7 csr low";
                else if (m == 0)                    tag = "R1 wide";
                else if (m == 1)                    tag = "R2 pair lower";
                else                                tag = "R3 pair upper";
                step(VECS[i], tag);
                if (m == 0) check("R6 spare low", {25'd0, q_out[27:25]}, '0);
                if (m != 0) check("R2 mirror", {14'd0, q_out[27:14]}, {14'd0, q_out[13:0]});
            end
        end

        // R3: the upper strap has no effect in wide mode
        enter_mode(1'b0, 1'b1);
        step('{25'h1234567, 1'b0, 1'b0}, "R3 wide ignores upper");

        // R9: gate follows the selects at the loading edge only
        step('{25'h0C0FFEE, 1'b0, 1'b0}, "R9 open");
        step('{25'h1BADBAD, 1'b1, 1'b1}, "R9 closed after open");
        step('{25'h0777777, 1'b0, 1'b1}, "R9 open after closed");

        // R5: reset in mid cycle with both selects high
        dcs_n = 1'b1;
        csr_n = 1'b1;
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        check("R5 reset over gate", {q_out, q_cs}, '0);
        @(posedge clk);
        #1;
        check("R5 held in reset", {q_out, q_cs}, '0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule